// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog that fires in two steps. A decrementing counter is advanced by a tick-enable input, which the surrounding system pulses once every 0.6 s, so a timeout of S seconds needs an initial value of S*10/6 ticks. When the count runs out for the first time, a timeout flag is set, an interrupt request is pulsed and the count starts again from the initial value. Software can clear the flag and reload the counter in the meantime. If the count runs out again while the flag is still set, a second-timeout flag is raised and a system reset request is asserted, unless a no-reboot input blocks it.

Software reaches the block through a small 16-bit register port. The port has a write strobe, an address and write data, and it returns read data combinationally for the address presented. Five registers are decoded:

| Address | Contents |
|---|---|
| 0x00 | Reload on any write; reads the live count in bits [9:0] |
| 0x04 | Status 1 |
| 0x06 | Status 2 |
| 0x08 | Control, with the halt bit in bit 11 |
| 0x12 | Initial value |

Every other address reads zero.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the count is 0, control reads 0x0800 (halted), the initial-value register reads 0x0004, status 1 and status 2 read 0, and irq and sys_rst_req are low.
- R2: Any write to address 0x00 loads the counter with the stored initial value. A read of 0x00 returns the count in bits [9:0] and zeros above.
- R3: While control bit 11 (halt) is 0, each tick lowers a nonzero count by one. While it is 1, ticks leave the count unchanged. The bit reads back as written.
- R4: Register 0x12 keeps bits [15:10] exactly as written. A write whose bits [9:0] are below 4 leaves the stored initial value in [9:0] unchanged.
- R5: An expiry is a tick, while not halted, that finds the count at 0. The expiry reloads the counter from the initial value. If status 1 bit 3 is clear, the expiry sets it (first expiry).
- R6: A first expiry pulses irq high for exactly one cycle when irq_en is 1. With irq_en at 0, irq stays low.
- R7: An expiry while status 1 bit 3 is set sets status 2 bit 1 and raises sys_rst_req. sys_rst_req then stays high until rst_n is asserted.
- R8: While no_reboot is 1, an expiry of the second kind still sets status 2 bit 1 but does not raise sys_rst_req.
- R9: Status 1 bit 3 and status 2 bits 1 and 2 clear when 1 is written to them. Writing 0 leaves them unchanged.
- R10: An expiry that finds status 2 bit 1 already set also sets status 2 bit 2 (boot status).
- R11: A reload write in the same cycle as a tick wins: the counter takes the initial value and no expiry is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable, one per 0.6 s |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq_en | input | 1 | Enables the first-expiry interrupt pulse |
| no_reboot | input | 1 | Blocks the reset request when high |
| irq | output | 1 | One-cycle interrupt request |
| sys_rst_req | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, a 10-bit count, a minimum initial value of 4 and a reset initial value of 4. With this minimum, an initial value of 5 gives a full countdown of six ticks. That is short enough to walk a first expiry, a second expiry and a boot-status expiry in a few dozen cycles. It also lets the bench write values just below the floor to show that they are refused.

// File: rtl/twostage_wdt.sv
module twostage_wdt #(
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 10,
  parameter int ADDR_W   = 5,
  parameter int INIT_MIN = 4,
  parameter int INIT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              irq_en,
  input  logic              no_reboot,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam int HI_W = DATA_W - CNT_W;
  localparam logic [ADDR_W-1:0] A_RLD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_ST1  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ST2  = ADDR_W'(8'h06);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(8'h12);

  logic [CNT_W-1:0] cnt, init_lo;
  logic [HI_W-1:0]  init_hi;
  logic halt, to_sts, sec_sts, boot_sts, irq_q, rreq_q;

  wire wr_rld  = reg_wr && reg_addr == A_RLD;
  wire wr_st1  = reg_wr && reg_addr == A_ST1;
  wire wr_st2  = reg_wr && reg_addr == A_ST2;
  wire wr_ctl  = reg_wr && reg_addr == A_CTL;
  wire wr_init = reg_wr && reg_addr == A_INIT;

  wire run        = tick && !halt && !wr_rld;
  wire expire     = run && cnt == '0;
  wire first_exp  = expire && !to_sts;
  wire second_exp = expire && to_sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      init_lo  <= CNT_W'(INIT_RST);
      init_hi  <= '0;
      halt     <= 1'b1;
      to_sts   <= 1'b0;
      sec_sts  <= 1'b0;
      boot_sts <= 1'b0;
      irq_q    <= 1'b0;
      rreq_q   <= 1'b0;
    end else begin
      if (wr_rld)      cnt <= init_lo;
      else if (expire) cnt <= init_lo;
      else if (run)    cnt <= cnt - 1'b1;

      if (wr_init) begin
        init_hi <= reg_wdata[DATA_W-1:CNT_W];
        if (reg_wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN)) init_lo <= reg_wdata[CNT_W-1:0];
      end

      if (wr_ctl) halt <= reg_wdata[11];

      if (first_exp)                  to_sts <= 1'b1;
      else if (wr_st1 && reg_wdata[3]) to_sts <= 1'b0;

      if (second_exp)                 sec_sts <= 1'b1;
      else if (wr_st2 && reg_wdata[1]) sec_sts <= 1'b0;

      if (second_exp && sec_sts)      boot_sts <= 1'b1;
      else if (wr_st2 && reg_wdata[2]) boot_sts <= 1'b0;

      if (second_exp && !no_reboot) rreq_q <= 1'b1;
      irq_q <= first_exp && irq_en;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RLD:  reg_rdata[CNT_W-1:0] = cnt;
      A_ST1:  reg_rdata[3] = to_sts;
      A_ST2:  reg_rdata[2:1] = {boot_sts, sec_sts};
      A_CTL:  reg_rdata[11] = halt;
      A_INIT: reg_rdata = {init_hi, init_lo};
      default: reg_rdata = '0;
    endcase
  end

  assign irq         = irq_q;
  assign sys_rst_req = rreq_q;
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
  parameter int CNT_W    = 10,
  parameter int ADDR_W   = 5,
  parameter int INIT_MIN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              no_reboot,
  input logic              irq,
  input logic              sys_rst_req,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  init_lo,
  input logic              halt,
  input logic              to_sts,
  input logic              sec_sts
);
  wire rld = reg_wr && reg_addr == '0;

  a_r2_reload_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rld |=> cnt == $past(init_lo));
  a_r3_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !rld) |=> $stable(cnt));
  a_r4_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
    init_lo >= CNT_W'(INIT_MIN));
  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r5_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> to_sts);
  a_r7_second_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_sts) |-> $past(to_sts));
  a_r7_reset_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);
  a_r8_noreboot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> !$past(no_reboot));
endmodule

bind twostage_wdt twostage_wdt_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .INIT_MIN(INIT_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .no_reboot(no_reboot), .irq(irq), .sys_rst_req(sys_rst_req),
  .cnt(cnt), .init_lo(init_lo), .halt(halt), .to_sts(to_sts), .sec_sts(sec_sts)
);

// File: tb/twostage_wdt_tb.sv
module twostage_wdt_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0, irq_en = 1'b0, no_reboot = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq, sys_rst_req;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  twostage_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en),
    .no_reboot(no_reboot), .irq(irq), .sys_rst_req(sys_rst_req));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, string req, logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd(5'h00, "R1 count", 16'h0000);
    rd(5'h08, "R1 control", 16'h0800);
    rd(5'h12, "R1 initial", 16'h0004);
    rd(5'h04, "R1 status1", 16'h0000);
    rd(5'h06, "R1 status2", 16'h0000);
    check("R1 irq/rst", {14'b0, irq, sys_rst_req}, 16'h0000);
  endtask

  task automatic t_init;
    wr(5'h12, 16'h0005);
    rd(5'h12, "R4 init write", 16'h0005);
    wr(5'h12, 16'hFC02);
    rd(5'h12, "R4 below floor, high kept", 16'hFC05);
    wr(5'h12, 16'h0003);
    rd(5'h12, "R4 value 3 ignored", 16'h0005);
  endtask

  task automatic t_reload_halt;
    wr(5'h00, 16'h1234);
    rd(5'h00, "R2 reload", 16'h0005);
    ticks(1);
    rd(5'h00, "R3 halted no count", 16'h0005);
    wr(5'h08, 16'h0000);
    rd(5'h08, "R3 halt readback", 16'h0000);
    ticks(1);
    rd(5'h00, "R3 decrement", 16'h0004);
  endtask

  task automatic t_first;
    irq_en = 1'b1;
    ticks(4);
    rd(5'h00, "R3 reach zero", 16'h0000);
    ticks(1);
    check("R6 irq pulse", {15'b0, irq}, 16'h0001);
    rd(5'h04, "R5 flag set", 16'h0008);
    rd(5'h00, "R5 reloaded", 16'h0005);
    @(negedge clk);
    check("R6 irq one cycle", {15'b0, irq}, 16'h0000);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    tick = 1'b1; reg_wr = 1'b1; reg_addr = 5'h00;
    @(negedge clk);
    tick = 1'b0; reg_wr = 1'b0;
    rd(5'h00, "R11 reload beats tick", 16'h0005);
  endtask

  task automatic t_noreboot;
    no_reboot = 1'b1;
    ticks(6);
    rd(5'h06, "R8 second flag set", 16'h0002);
    check("R8 reset blocked", {15'b0, sys_rst_req}, 16'h0000);
    ticks(6);
    rd(5'h06, "R10 boot flag", 16'h0006);
    check("R8 still blocked", {15'b0, sys_rst_req}, 16'h0000);
  endtask

  task automatic t_w1c;
    wr(5'h06, 16'h0000);
    rd(5'h06, "R9 write 0 keeps", 16'h0006);
    wr(5'h04, 16'h0000);
    rd(5'h04, "R9 write 0 keeps s1", 16'h0008);
    wr(5'h06, 16'h0006);
    rd(5'h06, "R9 clear s2", 16'h0000);
    wr(5'h04, 16'h0008);
    rd(5'h04, "R9 clear s1", 16'h0000);
  endtask

  task automatic t_reset_req;
    bit saw_irq = 1'b0;
    no_reboot = 1'b0; irq_en = 1'b0;
    wr(5'h00, 16'h0000);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (irq) saw_irq = 1'b1;
    end
    check("R6 irq gated", {15'b0, saw_irq}, 16'h0000);
    rd(5'h04, "R5 flag again", 16'h0008);
    ticks(6);
    rd(5'h06, "R7 second flag", 16'h0002);
    check("R7 reset request", {15'b0, sys_rst_req}, 16'h0001);
    wr(5'h06, 16'h0006);
    wr(5'h04, 16'h0008);
    check("R7 request sticky", {15'b0, sys_rst_req}, 16'h0001);
    do_reset();
    check("R7 cleared by reset", {15'b0, sys_rst_req}, 16'h0000);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_init();
    t_reload_halt();
    t_first();
    t_same_cycle();
    t_noreboot();
    t_w1c();
    t_reset_req();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule